// File: doc/BRIEF.md
# Packed Byte and Short to Half-Precision Converter

This unit is an execution slot for a custom instruction on a 32-bit processor. It turns packed integer pixels into pairs of 16-bit floating-point values and turns such pairs back into integers. A 32-bit operand holds four unsigned bytes or two signed shorts, and every operation writes a 32-bit result that holds two lanes. The upper lane occupies bits 31:16 and the lower lane occupies bits 15:0.

There are four byte-to-half selections. Two of them take the upper or the lower byte pair of one word. The other two pair neighbouring pixels so that filter taps reach the datapath already converted. One of these takes a byte from a second operand word that holds the preceding pixels. The unit also converts shorts to halves, halves to saturated shorts and halves to clamped bytes.

The processor presents the operands with a one-cycle start pulse. The unit returns the result with a one-cycle done pulse on the following clock. The result register keeps its value until the next start.

Top module: `byte_half_cvt`

## Requirements
- R1: When start is sampled high at a clock edge, done is high after that edge and result carries the converted value. When start is sampled low, done is low after that edge.
- R2: Reset (synchronous, active high) clears result and done to 0. While start is low, result keeps its value.
- R3: Opcode 0 (pair-high) converts byte src_a[31:24] into the upper lane and byte src_a[23:16] into the lower lane.
- R4: Opcode 1 (pair-low) converts src_a[15:8] into the upper lane and src_a[7:0] into the lower lane.
- R5: Opcode 2 (shift-low) converts src_a[7:0] into the upper lane and src_b[31:24], taken from the preceding word, into the lower lane.
- R6: Opcode 3 (shift-high) converts src_a[23:16] into the upper lane and src_a[15:8] into the lower lane.
- R7: Half layout: bit 15 is the sign, bits 14:10 are the exponent with bias 15, and bits 9:0 are the fraction. A byte of 0 gives 16'h0000. Every nonzero byte is encoded exactly, for example 1 gives 16'h3C00 and 255 gives 16'h5BF8.
- R8: Opcode 4 converts the signed shorts src_a[31:16] and src_a[15:0] to halves. When the magnitude needs more than 11 significant bits, the low significand bits are truncated.
- R9: Opcode 6 converts the halves src_a[31:16] and src_a[15:0] to bytes placed in result[15:8] and result[7:0], with result[31:16] set to 0. The fraction is truncated, negative inputs give 0, and values above 255 (including an all-ones exponent) give 255.
- R10: Opcode 5 converts the two halves in src_a to signed shorts in the same lanes. The fraction is truncated and the result saturates to 32767 and -32768. An all-ones exponent saturates according to the sign.
- R11: Opcode 7 is reserved and gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request, one cycle |
| op | input | 3 | Operation code |
| src_a | input | 32 | Main operand word |
| src_b | input | 32 | Preceding operand word (shift-low) |
| done | output | 1 | Result valid pulse |
| result | output | 32 | Converted lane pair |

## Verification
The datapath has no internal state besides the result and done registers, so a wrong lane selection or a wrong exponent or fraction computation shows up in result one clock after the start that triggers it. Faulty hold logic shows up as a result that changes on an idle cycle right after an operation. A faulty pulse shows up as a done that is missing or stuck on the cycle after start. A sweep of all 256 byte values, and halves placed at each clamp and saturation edge, expose wrong shift amounts and missing clamps on the first affected operation.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 16;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int BYTE_W = 8;
    localparam int EXP_W  = 5;
    localparam int FRAC_W = 10;
    localparam int BIAS   = 15;
    localparam int POS_W  = $clog2(LANE_W);
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    typedef enum logic [2:0] {
        OP_B2H_HI  = 3'd0,
        OP_B2H_LO  = 3'd1,
        OP_B2H_SLO = 3'd2,
        OP_B2H_SHI = 3'd3,
        OP_S2H     = 3'd4,
        OP_H2S     = 3'd5,
        OP_H2B     = 3'd6,
        OP_NONE    = 3'd7
    } cvt_op_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } half_t;

    typedef struct packed {
        logic              neg;
        logic [LANE_W-1:0] mag;
    } smag_t;

    function automatic logic [POS_W-1:0] lead_pos(input logic [LANE_W-1:0] m);
        lead_pos = '0;
        for (int i = 0; i < LANE_W; i++)
            if (m[i]) lead_pos = POS_W'(i);
    endfunction

    function automatic smag_t from_byte(input logic [BYTE_W-1:0] b);
        from_byte.neg = 1'b0;
        from_byte.mag = LANE_W'(b);
    endfunction

    function automatic smag_t from_short(input logic [LANE_W-1:0] s);
        from_short.neg = s[LANE_W-1];
        from_short.mag = s[LANE_W-1] ? (~s + 1'b1) : s;
    endfunction
endpackage

// File: rtl/lane_mux.sv
module lane_mux
    import cvt_pkg::*;
(
    input  cvt_op_e                  op,
    input  logic [DATA_W-1:0]        src_a,
    input  logic [DATA_W-1:0]        src_b,
    output smag_t [LANES-1:0]        lane_src
);
    logic [BYTE_W-1:0] prev_top;
    logic              unused_b;

    assign prev_top = src_b[DATA_W-1 -: BYTE_W];
    assign unused_b = ^src_b[DATA_W-BYTE_W-1:0];

    always_comb begin
        lane_src = '0;
        unique case (op)
            OP_B2H_HI: begin
                lane_src[1] = from_byte(src_a[31:24]);
                lane_src[0] = from_byte(src_a[23:16]);
            end
            OP_B2H_LO: begin
                lane_src[1] = from_byte(src_a[15:8]);
                lane_src[0] = from_byte(src_a[7:0]);
            end
            OP_B2H_SLO: begin
                lane_src[1] = from_byte(src_a[7:0]);
                lane_src[0] = from_byte(prev_top);
            end
            OP_B2H_SHI: begin
                lane_src[1] = from_byte(src_a[23:16]);
                lane_src[0] = from_byte(src_a[15:8]);
            end
            OP_S2H: begin
                for (int l = 0; l < LANES; l++)
                    lane_src[l] = from_short(src_a[l*LANE_W +: LANE_W]);
            end
            default: lane_src = '0;
        endcase
    end
endmodule

// File: rtl/half_enc.sv
module half_enc
    import cvt_pkg::*;
(
    input  smag_t src,
    output half_t dst
);
    logic [POS_W-1:0]         pos;
    logic [LANE_W+FRAC_W-1:0] aligned;

    assign pos     = lead_pos(src.mag);
    assign aligned = {src.mag, {FRAC_W{1'b0}}} >> pos;

    always_comb begin
        if (src.mag == '0) begin
            dst = '0;
        end else begin
            dst.sign = src.neg;
            dst.exp  = EXP_W'(BIAS) + EXP_W'(pos);
            dst.frac = aligned[FRAC_W-1:0];
        end
    end

    always_comb begin
        // R7
        enc_zero_chk: assert ((src.mag != '0) || (dst == '0));
        // R8
        enc_exp_range_chk: assert ((src.mag == '0) ||
            ((dst.exp >= EXP_W'(BIAS)) && (dst.exp < EXP_W'(EXP_MAX)) && (dst.sign == src.neg)));
    end
endmodule

// File: rtl/half_dec.sv
module half_dec
    import cvt_pkg::*;
(
    input  half_t              src,
    output logic [BYTE_W-1:0]  byte_o,
    output logic [LANE_W-1:0]  short_o
);
    logic              overflow;
    logic              below_one;
    logic [EXP_W-1:0]  shamt;
    logic [LANE_W-1:0] mag;

    assign overflow  = (src.exp == EXP_W'(EXP_MAX));
    assign below_one = (src.exp < EXP_W'(BIAS));
    assign shamt     = src.exp - EXP_W'(BIAS);

    always_comb begin
        if (below_one || overflow)
            mag = '0;
        else
            mag = LANE_W'(({{LANE_W{1'b0}}, 1'b1, src.frac} << shamt) >> FRAC_W);
    end

    always_comb begin
        if (src.sign)
            byte_o = '0;
        else if (overflow || (mag > LANE_W'(255)))
            byte_o = '1;
        else
            byte_o = mag[BYTE_W-1:0];
    end

    always_comb begin
        if (!src.sign) begin
            if (overflow || mag[LANE_W-1])
                short_o = {1'b0, {(LANE_W-1){1'b1}}};
            else
                short_o = mag;
        end else begin
            if (overflow || (mag > {1'b1, {(LANE_W-1){1'b0}}}))
                short_o = {1'b1, {(LANE_W-1){1'b0}}};
            else
                short_o = ~mag + 1'b1;
        end
    end

    always_comb begin
        // R9
        dec_neg_byte_chk: assert (!src.sign || (byte_o == '0));
        // R10
        dec_short_sign_chk: assert ((short_o == '0) || (short_o[LANE_W-1] == src.sign));
    end
endmodule

// File: rtl/byte_half_cvt.sv
module byte_half_cvt
    import cvt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  op,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic        done,
    output logic [31:0] result
);
    cvt_op_e                      op_e;
    smag_t [LANES-1:0]            lane_src;
    half_t [LANES-1:0]            enc_out;
    logic  [LANES-1:0][BYTE_W-1:0] dec_byte;
    logic  [LANES-1:0][LANE_W-1:0] dec_short;
    logic  [DATA_W-1:0]           next_result;

    assign op_e = cvt_op_e'(op);

    lane_mux u_mux (
        .op       (op_e),
        .src_a    (src_a),
        .src_b    (src_b),
        .lane_src (lane_src)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        half_enc u_enc (
            .src (lane_src[l]),
            .dst (enc_out[l])
        );
        half_dec u_dec (
            .src     (half_t'(src_a[l*LANE_W +: LANE_W])),
            .byte_o  (dec_byte[l]),
            .short_o (dec_short[l])
        );
    end

    always_comb begin
        unique case (op_e)
            OP_B2H_HI, OP_B2H_LO, OP_B2H_SLO, OP_B2H_SHI, OP_S2H:
                next_result = enc_out;
            OP_H2S:  next_result = dec_short;
            OP_H2B:  next_result = {{(DATA_W - LANES*BYTE_W){1'b0}}, dec_byte};
            default: next_result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= start;
            if (start) result <= next_result;
        end
    end

    // R1
    done_follows_start_chk: assert property (@(posedge clk) disable iff (rst) start |=> done);
    // R1
    idle_no_done_chk: assert property (@(posedge clk) disable iff (rst) !start |=> !done);
    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(result));
    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd7) |=> (result == '0));
    // R9
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'd6) |=> (result[31:16] == '0));
endmodule

// File: tb/test_byte_half_cvt.sv
module test_byte_half_cvt;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        done;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_half_cvt i_byte_half_cvt (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .done(done), .result(result)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: integer with sign to half, fraction by division.
    function automatic logic [15:0] ref_enc(input bit neg, input int mag);
        int p;
        int fr;
        if (mag == 0) return 16'h0000;
        p = 0;
        while ((mag / (1 << (p + 1))) > 0) p++;
        fr = ((mag - (1 << p)) * 1024) / (1 << p);
        return {neg, 5'(15 + p), 10'(fr)};
    endfunction

    function automatic longint ref_mag(input logic [15:0] h);
        int e;
        e = int'(h[14:10]);
        if (e == 31) return 64'd1 << 40;
        if (e < 15) return 0;
        return ((1024 + longint'(h[9:0])) * (64'd1 << (e - 15))) / 1024;
    endfunction

    function automatic logic [7:0] ref_byte(input logic [15:0] h);
        longint m;
        m = ref_mag(h);
        if (h[15]) return 8'd0;
        if (m > 255) return 8'd255;
        return 8'(m);
    endfunction

    function automatic logic [15:0] ref_short(input logic [15:0] h);
        longint m;
        m = ref_mag(h);
        if (!h[15]) return (m > 32767) ? 16'h7FFF : 16'(m);
        if (m > 32768) return 16'h8000;
        return 16'(-m);
    endfunction

    function automatic logic [15:0] ref_s2h(input logic [15:0] s);
        int v;
        v = int'($signed(s));
        return ref_enc(v < 0, (v < 0) ? -v : v);
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op = o; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 done", {31'b0, done}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R2 reset result", result, 32'h0);
        chk("R2 reset done", {31'b0, done}, 32'd0);
    endtask

    task automatic t_hi;
        run_op(3'd0, 32'h01FF_8007, 32'h0);
        chk("R3 R7 pair-high", result, 32'h3C00_5BF8);
    endtask

    task automatic t_lo;
        run_op(3'd1, 32'h01FF_8007, 32'h0);
        chk("R4 pair-low", result, {ref_enc(0, 8'h80), ref_enc(0, 7)});
        run_op(3'd1, 32'h0000_0000, 32'h0);
        chk("R7 zero byte", result, 32'h0);
    endtask

    task automatic t_slo;
        run_op(3'd2, 32'h1122_3344, 32'hC855_6677);
        chk("R5 shift-low", result, {ref_enc(0, 8'h44), ref_enc(0, 8'hC8)});
    endtask

    task automatic t_shi;
        run_op(3'd3, 32'h1122_3344, 32'hFFFF_FFFF);
        chk("R6 shift-high", result, {ref_enc(0, 8'h22), ref_enc(0, 8'h33)});
    endtask

    task automatic t_sweep;
        for (int v = 0; v < 256; v += 2) begin
            run_op(3'd0, {8'(v), 8'(v + 1), 16'h0}, 32'h0);
            chk("R7 byte sweep", result, {ref_enc(0, v), ref_enc(0, v + 1)});
        end
    endtask

    task automatic t_s2h;
        run_op(3'd4, 32'h7FFF_8000, 32'h0);
        chk("R8 short extremes", result, {ref_s2h(16'h7FFF), 16'hF800});
        run_op(3'd4, 32'hFFFD_0801, 32'h0);
        chk("R8 truncation", result, 32'hC200_6800);
    endtask

    task automatic t_h2b;
        run_op(3'd6, 32'h5BF8_3C00, 32'hFFFF_FFFF);
        chk("R9 exact bytes", result, 32'h0000_FF01);
        run_op(3'd6, 32'hC000_5C00, 32'h0);
        chk("R9 clamp", result, 32'h0000_00FF);
        run_op(3'd6, 32'h3E00_7C00, 32'h0);
        chk("R9 trunc and inf", result, {16'h0, ref_byte(16'h3E00), ref_byte(16'h7C00)});
    endtask

    task automatic t_h2s;
        run_op(3'd5, 32'h7BFF_FBFF, 32'h0);
        chk("R10 saturate", result, 32'h7FFF_8000);
        run_op(3'd5, 32'hC600_3800, 32'h0);
        chk("R10 negative and fraction", result, 32'hFFFA_0000);
        run_op(3'd5, 32'h5A4D_FC00, 32'h0);
        chk("R10 general", result, {ref_short(16'h5A4D), ref_short(16'hFC00)});
    endtask

    task automatic t_none;
        run_op(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R11 reserved", result, 32'h0);
    endtask

    task automatic t_hold;
        logic [31:0] kept;
        run_op(3'd0, 32'hFF01_0000, 32'h0);
        kept = result;
        op = 3'd7; src_a = 32'h1234_5678;
        @(negedge clk);
        chk("R1 idle done low", {31'b0, done}, 32'd0);
        chk("R2 result held", result, kept);
        @(negedge clk);
        chk("R2 result held later", result, 32'h5BF8_3C00);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hi();
        t_lo();
        t_slo();
        t_shi();
        t_sweep();
        t_s2h();
        t_h2b();
        t_h2s();
        t_none();
        t_hold();
        finished = 1;
        summary();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule